// File: doc/BRIEF.md
# Display Window and Pixel Streamer

This block draws a rectangle on a serially attached display controller. A draw request carries two corner points and a mode flag. The block adds fixed panel offsets to both corners and sends the controller a column window, a row window and a memory-write opcode. Each of these bytes goes out in its own chip-select frame. The block then streams 16-bit pixels inside one long chip-select frame. The frame ends when the last bit has left the shifter.

In fill mode one colour word, captured with the request, is repeated for every pixel of the rectangle. In picture mode pixels come from a valid/ready stream. If no pixel is offered, the shifter waits with the clock parked high and chip select still low. A request made while a draw is in progress is dropped. A one-cycle `done` pulse marks the end of each draw.

Top module: `lcd_window_streamer`

## Requirements
- R1: After an accepted request the block sends 11 header bytes in this order: 0x2A, X1 high, X1 low, X2 high, X2 low, 0x2B, Y1 high, Y1 low, Y2 high, Y2 low, 0x2C. Each coordinate is the requested value plus the parameter OFFSET_X (for X) or OFFSET_Y (for Y), taken modulo 2^16.
- R2: `lcd_dc` is 0 while each of the three opcode bytes (0x2A, 0x2B, 0x2C) is shifted. It is 1 for every coordinate byte and every pixel byte.
- R3: Each header byte has its own chip-select-low frame of exactly 8 clocks. Bits go MSB first. `lcd_sclk` idles high, and `lcd_mosi` is stable at every rising edge of `lcd_sclk`, where the receiver samples it.
- R4: The pixel burst holds (x2-x1+1)*(y2-y1+1) pixels, given x2>=x1 and y2>=y1. Each pixel is 16 bits, sent high byte first.
- R5: The whole pixel burst is one chip-select-low frame of 16 clocks per pixel.
- R6: With `req_fill`=1, every pixel equals the `req_color` captured at acceptance. `pix_ready` stays 0, so no stream pixel is consumed.
- R7: With `req_fill`=0, pixel k of the burst is the k-th word taken on a cycle where `pix_valid` and `pix_ready` are both 1. While no pixel is offered, `lcd_cs_n` stays 0, `lcd_sclk` stays 1 and `pix_ready` stays 1.
- R8: `busy` rises in the cycle after a request is accepted while idle. `busy` falls, `lcd_cs_n` rises and `done` is 1 for exactly one cycle, all in the cycle after the last pixel bit completes.
- R9: A `req_start` made while `busy` is 1 is ignored. The running draw's bytes are unchanged and no further frame follows it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_start | input | 1 | Draw request, taken when idle |
| req_fill | input | 1 | 1 = fill with colour, 0 = picture stream |
| req_x1 | input | 16 | Left column |
| req_y1 | input | 16 | Top row |
| req_x2 | input | 16 | Right column |
| req_y2 | input | 16 | Bottom row |
| req_color | input | 16 | Fill colour |
| pix_data | input | 16 | Picture pixel word |
| pix_valid | input | 1 | Picture pixel offered |
| pix_ready | output | 1 | Picture pixel accepted this cycle when valid |
| busy | output | 1 | Draw in progress |
| done | output | 1 | One-cycle end-of-draw pulse |
| lcd_cs_n | output | 1 | Serial chip select, active low |
| lcd_dc | output | 1 | 0 = opcode byte, 1 = data |
| lcd_sclk | output | 1 | Serial clock, idles high |
| lcd_mosi | output | 1 | Serial data out |

## Verification
The hardest state to reach is a stall in picture mode. The header must be fully sent and the burst frame already open, yet no pixel is available. The bench holds `pix_valid` low through the whole header and for a long time after. It then looks at the serial pins and `pix_ready` in the middle of the stall, and afterwards lets pixels through with a gapped valid pattern. A second hard case is a new request that arrives during a draw. The bench injects different coordinates during a fill and compares the bytes captured on the wire with the first request only.

// File: rtl/lcd_window_streamer.sv
module lcd_window_streamer #(
  parameter int OFFSET_X = 0,
  parameter int OFFSET_Y = 0,
  parameter int HALF_BIT = 2
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        req_start,
  input  logic        req_fill,
  input  logic [15:0] req_x1,
  input  logic [15:0] req_y1,
  input  logic [15:0] req_x2,
  input  logic [15:0] req_y2,
  input  logic [15:0] req_color,
  input  logic [15:0] pix_data,
  input  logic        pix_valid,
  output logic        pix_ready,
  output logic        busy,
  output logic        done,
  output logic        lcd_cs_n,
  output logic        lcd_dc,
  output logic        lcd_sclk,
  output logic        lcd_mosi
);
  localparam int DIV_W = (HALF_BIT > 1) ? $clog2(HALF_BIT) : 1;
  localparam logic [DIV_W-1:0] DIV_MAX = DIV_W'(HALF_BIT - 1);
  localparam int CNT_W = 34;
  localparam logic [3:0] LAST_HDR = 4'd10;

  typedef enum logic [2:0] {IDLE, HDR, HDR_GO, HDR_END, PIX_CS, PIX_GET, PIX_NEXT} st_t;

  st_t              state;
  logic [15:0]      x1o, x2o, y1o, y2o, color_r, shreg;
  logic             fill_r, active, sclk_r, cs_r, dc_r, done_r;
  logic [3:0]       byte_idx;
  logic [4:0]       bits_left;
  logic [DIV_W-1:0] div_cnt;
  logic [CNT_W-1:0] pix_left;
  logic [16:0]      span_x, span_y;
  logic [7:0]       hdr_byte;
  logic             is_cmd;

  assign span_x = {1'b0, req_x2} - {1'b0, req_x1} + 17'd1;
  assign span_y = {1'b0, req_y2} - {1'b0, req_y1} + 17'd1;
  assign is_cmd = (byte_idx == 4'd0) || (byte_idx == 4'd5) || (byte_idx == 4'd10);

  always_comb begin
    case (byte_idx)
      4'd0:    hdr_byte = 8'h2A;
      4'd1:    hdr_byte = x1o[15:8];
      4'd2:    hdr_byte = x1o[7:0];
      4'd3:    hdr_byte = x2o[15:8];
      4'd4:    hdr_byte = x2o[7:0];
      4'd5:    hdr_byte = 8'h2B;
      4'd6:    hdr_byte = y1o[15:8];
      4'd7:    hdr_byte = y1o[7:0];
      4'd8:    hdr_byte = y2o[15:8];
      4'd9:    hdr_byte = y2o[7:0];
      default: hdr_byte = 8'h2C;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state     <= IDLE;
      x1o       <= '0;
      x2o       <= '0;
      y1o       <= '0;
      y2o       <= '0;
      color_r   <= '0;
      shreg     <= '0;
      fill_r    <= 1'b0;
      active    <= 1'b0;
      sclk_r    <= 1'b1;
      cs_r      <= 1'b1;
      dc_r      <= 1'b1;
      done_r    <= 1'b0;
      byte_idx  <= '0;
      bits_left <= '0;
      div_cnt   <= '0;
      pix_left  <= '0;
    end else begin
      done_r <= 1'b0;
      if (active) begin
        if (div_cnt == DIV_MAX) begin
          div_cnt <= '0;
          if (!sclk_r) sclk_r <= 1'b1;
          else if (bits_left == 5'd1) active <= 1'b0;
          else begin
            bits_left <= bits_left - 5'd1;
            shreg     <= {shreg[14:0], 1'b0};
            sclk_r    <= 1'b0;
          end
        end else begin
          div_cnt <= div_cnt + 1'b1;
        end
      end else begin
        case (state)
          IDLE: if (req_start) begin
            x1o      <= req_x1 + 16'(OFFSET_X);
            x2o      <= req_x2 + 16'(OFFSET_X);
            y1o      <= req_y1 + 16'(OFFSET_Y);
            y2o      <= req_y2 + 16'(OFFSET_Y);
            fill_r   <= req_fill;
            color_r  <= req_color;
            pix_left <= CNT_W'(span_x) * CNT_W'(span_y);
            byte_idx <= '0;
            state    <= HDR;
          end
          HDR: begin
            cs_r  <= 1'b0;
            dc_r  <= ~is_cmd;
            state <= HDR_GO;
          end
          HDR_GO: begin
            shreg     <= {hdr_byte, 8'h00};
            bits_left <= 5'd8;
            active    <= 1'b1;
            sclk_r    <= 1'b0;
            div_cnt   <= '0;
            state     <= HDR_END;
          end
          HDR_END: begin
            cs_r <= 1'b1;
            if (byte_idx == LAST_HDR) state <= PIX_CS;
            else begin
              byte_idx <= byte_idx + 4'd1;
              state    <= HDR;
            end
          end
          PIX_CS: begin
            cs_r  <= 1'b0;
            dc_r  <= 1'b1;
            state <= PIX_GET;
          end
          PIX_GET: if (fill_r || pix_valid) begin
            shreg     <= fill_r ? color_r : pix_data;
            bits_left <= 5'd16;
            active    <= 1'b1;
            sclk_r    <= 1'b0;
            div_cnt   <= '0;
            pix_left  <= pix_left - 1'b1;
            state     <= PIX_NEXT;
          end
          PIX_NEXT: begin
            if (pix_left == '0) begin
              cs_r   <= 1'b1;
              done_r <= 1'b1;
              state  <= IDLE;
            end else begin
              state <= PIX_GET;
            end
          end
          default: state <= IDLE;
        endcase
      end
    end
  end

  assign pix_ready = (state == PIX_GET) && !active && !fill_r;
  assign busy      = (state != IDLE);
  assign done      = done_r;
  assign lcd_cs_n  = cs_r;
  assign lcd_dc    = dc_r;
  assign lcd_sclk  = sclk_r;
  assign lcd_mosi  = shreg[15];
endmodule

// File: rtl/lcd_window_streamer_chk.sv
module lcd_window_streamer_chk (
  input logic clk,
  input logic rst_n,
  input logic req_start,
  input logic pix_valid,
  input logic pix_ready,
  input logic busy,
  input logic done,
  input logic lcd_cs_n,
  input logic lcd_dc,
  input logic lcd_sclk,
  input logic lcd_mosi
);
  p_idle_cs_high_r8: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> lcd_cs_n);
  p_done_single_r8: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);
  p_done_ends_busy_r8: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> (!busy && $past(busy)));
  p_start_accept_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy && req_start) |=> busy);
  p_sclk_idle_r3: assert property (@(posedge clk) disable iff (!rst_n)
    lcd_cs_n |-> lcd_sclk);
  p_mosi_stable_r3: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(lcd_sclk) |-> $stable(lcd_mosi));
  p_ready_in_burst_r7: assert property (@(posedge clk) disable iff (!rst_n)
    pix_ready |-> (busy && !lcd_cs_n && lcd_dc));
  p_stall_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (pix_ready && !pix_valid) |=> (pix_ready && !lcd_cs_n && lcd_sclk));
endmodule

bind lcd_window_streamer lcd_window_streamer_chk u_chk (.*);

// File: tb/sim_lcd_window_streamer.sv
module sim_lcd_window_streamer;
  localparam int CLK_PERIOD = 10;
  localparam int OX = 3;
  localparam int OY = 5;
  // fields: x1, y1, x2, y2, fill, color
  localparam logic [80:0] VEC [4] = '{
    {16'd0,     16'd0,  16'd0,     16'd0,  1'b1, 16'hF800},
    {16'd2,     16'd1,  16'd4,     16'd2,  1'b1, 16'h07E0},
    {16'h00FF,  16'd0,  16'h0100,  16'd0,  1'b0, 16'h0000},
    {16'd10,    16'd20, 16'd10,    16'd22, 1'b0, 16'h0000}
  };

  logic clk = 0, rst_n = 0;
  logic req_start = 0, req_fill = 0;
  logic [15:0] req_x1 = 0, req_y1 = 0, req_x2 = 0, req_y2 = 0, req_color = 0;
  logic [15:0] pix_data;
  logic pix_valid = 0;
  logic pix_ready, busy, done, lcd_cs_n, lcd_dc, lcd_sclk, lcd_mosi;

  int tests = 0, fails = 0;
  int pix_idx = 0;
  bit feed_en = 0, gappy = 0;

  int nbytes = 0, nframes = 0, bitc = 0;
  logic [7:0] acc = 0;
  logic [7:0] bytes_log [512];
  logic       dc_log [512];
  int         fbits [256];
  logic prev_cs = 1, prev_sclk = 1;

  always #(CLK_PERIOD/2) clk = ~clk;

  lcd_window_streamer #(.OFFSET_X(OX), .OFFSET_Y(OY), .HALF_BIT(2)) u0 (.*);

  function automatic logic [15:0] pix_word(int k);
    return 16'hA000 + 16'(k) * 16'h0111;
  endfunction
  assign pix_data = pix_word(pix_idx);

  always @(posedge clk) if (pix_valid && pix_ready) pix_idx <= pix_idx + 1;

  initial begin
    int tick = 0;
    forever begin
      @(negedge clk);
      tick++;
      pix_valid = feed_en && (!gappy || tick[1]);
    end
  end

  always @(negedge clk) begin
    if (prev_cs && !lcd_cs_n) begin
      fbits[nframes] = 0;
      nframes = nframes + 1;
      bitc = 0;
    end
    if (!lcd_cs_n && lcd_sclk && !prev_sclk) begin
      acc = {acc[6:0], lcd_mosi};
      bitc = bitc + 1;
      fbits[nframes-1] = fbits[nframes-1] + 1;
      if (bitc == 8) begin
        bytes_log[nbytes] = acc;
        dc_log[nbytes] = lcd_dc;
        nbytes = nbytes + 1;
        bitc = 0;
      end
    end
    prev_cs = lcd_cs_n;
    prev_sclk = lcd_sclk;
  end

  task automatic check(bit ok, string req, string what, longint act, longint exp);
    tests++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  task automatic summary();
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    tests++; fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    summary();
  end

  function automatic logic [7:0] hdr_exp(int k, logic [15:0] a1, logic [15:0] b1,
                                         logic [15:0] a2, logic [15:0] b2);
    case (k)
      0: return 8'h2A;  1: return a1[15:8]; 2: return a1[7:0];
      3: return a2[15:8]; 4: return a2[7:0]; 5: return 8'h2B;
      6: return b1[15:8]; 7: return b1[7:0]; 8: return b2[15:8];
      9: return b2[7:0]; default: return 8'h2C;
    endcase
  endfunction

  task automatic run_req(logic [15:0] x1, logic [15:0] y1, logic [15:0] x2, logic [15:0] y2,
                         bit fill, logic [15:0] color, bit hold, bit gap, bit poke);
    int b0, f0, p0, n, t;
    logic [15:0] ax1, ax2, by1, by2, w;
    logic [7:0] e;
    b0 = nbytes; f0 = nframes; p0 = pix_idx;
    n = (int'(x2) - int'(x1) + 1) * (int'(y2) - int'(y1) + 1);
    ax1 = x1 + 16'(OX); ax2 = x2 + 16'(OX); by1 = y1 + 16'(OY); by2 = y2 + 16'(OY);
    gappy = gap;
    feed_en = !fill && !hold;
    @(negedge clk);
    req_x1 = x1; req_y1 = y1; req_x2 = x2; req_y2 = y2; req_fill = fill; req_color = color;
    req_start = 1;
    @(negedge clk);
    req_start = 0;
    check(busy == 1, "R8", "busy after accept", busy, 1);
    if (poke) begin
      repeat (100) @(negedge clk);
      req_x1 = 16'h0777; req_y1 = 16'h0555; req_x2 = 16'h0778; req_y2 = 16'h0556;
      req_fill = 0; req_color = 16'h1234; req_start = 1;
      @(negedge clk);
      req_start = 0;
    end
    if (hold) begin
      repeat (700) @(negedge clk);
      check(lcd_cs_n == 0 && lcd_sclk == 1 && lcd_dc == 1, "R7", "stall pins cs/sclk/dc",
            {lcd_cs_n, lcd_sclk, lcd_dc}, 3'b011);
      check(pix_ready == 1 && busy == 1, "R7", "stall ready/busy", {pix_ready, busy}, 2'b11);
      check(pix_idx == p0, "R7", "nothing consumed in stall", pix_idx - p0, 0);
      feed_en = 1;
    end
    t = 0;
    while (done !== 1'b1 && t < 20000) begin @(negedge clk); t++; end
    check(t < 20000, "R8", "done seen", t, 0);
    check(busy == 0 && lcd_cs_n == 1, "R8", "busy low and cs high with done",
          {busy, lcd_cs_n}, 2'b01);
    feed_en = 0;
    @(negedge clk);
    check(done == 0, "R8", "done lasts one cycle", done, 0);
    check(nbytes - b0 == 11 + 2 * n, "R4", "byte count", nbytes - b0, 11 + 2 * n);
    check(nframes - f0 == 12, "R5", "frame count", nframes - f0, 12);
    for (int k = 0; k < 11; k++) begin
      e = hdr_exp(k, ax1, by1, ax2, by2);
      check(bytes_log[b0+k] == e, "R1", $sformatf("header byte %0d", k), bytes_log[b0+k], e);
      check(dc_log[b0+k] == !(k == 0 || k == 5 || k == 10), "R2",
            $sformatf("dc on header byte %0d", k), dc_log[b0+k], !(k == 0 || k == 5 || k == 10));
      check(fbits[f0+k] == 8, "R3", $sformatf("frame %0d bits", k), fbits[f0+k], 8);
    end
    check(fbits[f0+11] == 16 * n, "R5", "burst frame bits", fbits[f0+11], 16 * n);
    for (int j = 0; j < 2 * n; j++) begin
      w = fill ? color : pix_word(p0 + j / 2);
      e = (j % 2 == 0) ? w[15:8] : w[7:0];
      check(bytes_log[b0+11+j] == e, fill ? "R6" : "R7", $sformatf("pixel byte %0d", j),
            bytes_log[b0+11+j], e);
      check(dc_log[b0+11+j] == 1, "R2", "dc on pixel byte", dc_log[b0+11+j], 1);
    end
    if (fill) check(pix_idx == p0, "R6", "stream untouched in fill", pix_idx - p0, 0);
    else check(pix_idx - p0 == n, "R7", "pixels consumed", pix_idx - p0, n);
    if (poke) begin
      repeat (60) @(negedge clk);
      check(nframes == f0 + 12 && busy == 0, "R9", "no transfer from ignored request",
            nframes - f0, 12);
    end
  endtask

  initial begin
    repeat (3) @(negedge clk);
    check({lcd_cs_n, lcd_sclk, busy, done, pix_ready} == 5'b11000, "R8", "reset outputs",
          {lcd_cs_n, lcd_sclk, busy, done, pix_ready}, 5'b11000);
    rst_n = 1;
    repeat (2) @(negedge clk);
    for (int i = 0; i < 4; i++)
      run_req(VEC[i][80:65], VEC[i][64:49], VEC[i][48:33], VEC[i][32:17], VEC[i][16],
              VEC[i][15:0], 0, 0, 0);
    // R7: picture burst stalled past the header, then gapped valid
    run_req(16'd0, 16'd0, 16'd1, 16'd1, 0, 16'h0, 1, 1, 0);
    // R9: second request during a fill draw
    run_req(16'd5, 16'd6, 16'd7, 16'd6, 1, 16'h5AA5, 0, 0, 1);
    // R1: offsets wrap past 16 bits
    run_req(16'hFFFE, 16'hFFFC, 16'hFFFE, 16'hFFFC, 1, 16'h0F0F, 0, 0, 0);
    summary();
  end
endmodule